// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the register updates a processor core needs when it takes an external interrupt. When a request arrives while interrupts are enabled, it captures the core's current context: the status word, user-mode flag, PC, stack pointer, kernel stack pointer, exception base and vector number. It then issues the writes in a fixed order. First it drops the user-mode flag. Next it writes the rebuilt status word, swaps stacks if the core came from user mode, and records the return PC together with the two exception-status fields. Last, it reads the handler address from the vector table through a single-beat 32-bit read port.

The core drives its live register values into the block and applies each write strobe with its data in the cycle the strobe is high. The sequence ends with a one-cycle completion pulse. On success, that pulse comes with a PC write carrying the handler address. If the table read returns an error, the pulse is a reject, and the reported PC is the unchanged return PC with no PC write. Requests that arrive while the block is busy, or while interrupts are disabled, are dropped.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, every write strobe, `rd_req`, `done_ok` and `done_rej` are low.
- R2: A request seen while `irq_en` is low is dropped: `busy` stays low and no strobe or read request follows.
- R3: On an accepted request (`irq_req` and `irq_en` high in IDLE at a clock edge), `umode_clr` is high for exactly the next cycle, with no other write strobe in that cycle. No other register write happens before it.
- R4: In the cycle after `umode_clr`, `status_we` is high and `status_wdata` equals ((old << 10) AND 0x3FFF_FFFF) OR (old AND 0x8000_0000). Here old is the status word captured at acceptance.
- R5: In that same cycle, if the captured `user_mode` was 1, `usp_we` writes the captured SP and `sp_we` writes the captured kernel SP. If it was 0, neither strobe is raised.
- R6: In that same cycle, `erp_we` writes the captured PC, `exs_we` writes vector × 256, and `eda_we` writes 0. Later changes on the context inputs have no effect.
- R7: In the next cycle, `rd_req` is high for one cycle, and `rd_addr` is the captured exception base plus vector × 4.
- R8: A response (`rd_valid`) is taken from the cycle after `rd_req` onward. When it arrives without `rd_err`, the next cycle raises `done_ok` and `pc_we`. `pc_wdata` and `result_pc` then both equal the handler address. Byte lane k (`rd_data[8k+7:8k]`) holds the table byte at address+k, and lane 0 is the least significant byte of the PC (little-endian).
- R9: A response with `rd_err` high instead raises `done_rej` for one cycle, keeps `pc_we` low, and makes `result_pc` the captured PC.
- R10: `busy` is high from the cycle after acceptance through the completion cycle and low afterwards. Requests arriving while it is high start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | 8 | Interrupt vector number |
| irq_en | input | 1 | Interrupt enable flag of the core |
| user_mode | input | 1 | Core currently in user mode |
| cur_status | input | 32 | Current status word |
| cur_pc | input | 32 | Current PC (return address) |
| cur_sp | input | 32 | Current stack pointer |
| kernel_sp | input | 32 | Kernel stack pointer value |
| exc_base | input | 32 | Vector table base address |
| rd_req | output | 1 | Vector table read request, one cycle |
| rd_addr | output | 32 | Vector table read address |
| rd_valid | input | 1 | Read response valid |
| rd_err | input | 1 | Read response error |
| rd_data | input | 32 | Read response data, lane k = byte at address+k |
| umode_clr | output | 1 | Clear the user-mode flag |
| status_we | output | 1 | Status word write strobe |
| status_wdata | output | 32 | New status word |
| usp_we | output | 1 | User-SP register write strobe |
| usp_wdata | output | 32 | Value for user-SP register |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | Value for stack pointer |
| erp_we | output | 1 | Exception return register write strobe |
| erp_wdata | output | 32 | Return PC |
| exs_we | output | 1 | Exception status write strobe |
| exs_wdata | output | 32 | Vector × 256 |
| eda_we | output | 1 | Exception data address write strobe |
| eda_wdata | output | 32 | Always zero |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | 32 | Handler address |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | Accepted completion pulse |
| done_rej | output | 1 | Rejected completion pulse |
| result_pc | output | 32 | Final PC, valid with a completion pulse |

## Verification
Counting from the edge that accepts a request, the user-mode clear is due one cycle later. The state-save writes are due at two cycles and the table read request at three. The completion pulse comes one cycle after the edge that samples the read response, and `busy` falls one cycle after that. The bench drives inputs on the falling edge and checks each of these results at the falling edge of the exact cycle in which it is due. Each step is checked both for the strobe it should raise and for the strobes it must hold low. The context inputs are scrambled straight after acceptance, and a request is injected while the block is busy, so that both capture and busy-time rejection are shown at the ports.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt entry sequencer.
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_KERN  = 3'd1,
        ST_SAVE  = 3'd2,
        ST_FETCH = 3'd3,
        ST_WAIT  = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/irq_status_xform.sv
// Builds the saved status word: the low field is shifted left and truncated
// to FIELD_W bits, and the top bit of the old word is carried unchanged.
// Assumes SHIFT < FIELD_W < W.
module irq_status_xform #(
    parameter int W       = 32,
    parameter int SHIFT   = 10,
    parameter int FIELD_W = 30
) (
    input  logic [W-1:0] old_status,
    output logic [W-1:0] new_status
);
    localparam logic [W-1:0] FIELD_MASK = W'((64'd1 << FIELD_W) - 64'd1);
    localparam logic [W-1:0] KEEP_MASK  = W'(64'd1 << (W - 1));

    // Shift, truncate to the field, and merge the preserved top bit.
    always_comb begin
        new_status = ((old_status << SHIFT) & FIELD_MASK) | (old_status & KEEP_MASK);
    end
endmodule

// File: rtl/irq_vec_fetch.sv
// Computes the vector table address and assembles the handler address from
// the read data lanes in little-endian order (lane 0 is the lowest byte).
// Assumes the table entry is exactly BYTES bytes wide.
module irq_vec_fetch #(
    parameter int AW          = 32,
    parameter int VEC_W       = 8,
    parameter int STRIDE_LOG2 = 2
) (
    input  logic [AW-1:0]    base,
    input  logic [VEC_W-1:0] vec,
    input  logic [AW-1:0]    rd_data,
    output logic [AW-1:0]    addr,
    output logic [AW-1:0]    handler
);
    localparam int BYTES = AW / 8;

    // Table entry address: base plus vector times the entry size.
    always_comb begin
        addr = base + (AW'(vec) << STRIDE_LOG2);
    end

    // Byte lane k of the response holds address+k, i.e. PC byte k.
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign handler[8*k +: 8] = rd_data[8*k +: 8];
    end
endmodule

// File: rtl/irq_ctx_capture.sv
// Holds the core context sampled in the cycle a request is accepted so
// that later writes use one consistent snapshot. Assumes load is a pulse.
module irq_ctx_capture #(
    parameter int W     = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] vec_in,
    input  logic             user_in,
    input  logic [W-1:0]     status_in,
    input  logic [W-1:0]     pc_in,
    input  logic [W-1:0]     sp_in,
    input  logic [W-1:0]     ksp_in,
    input  logic [W-1:0]     base_in,
    output logic [VEC_W-1:0] vec_q,
    output logic             user_q,
    output logic [W-1:0]     status_q,
    output logic [W-1:0]     pc_q,
    output logic [W-1:0]     sp_q,
    output logic [W-1:0]     ksp_q,
    output logic [W-1:0]     base_q
);
    // Snapshot register bank, cleared on reset, loaded on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q    <= '0;
            user_q   <= 1'b0;
            status_q <= '0;
            pc_q     <= '0;
            sp_q     <= '0;
            ksp_q    <= '0;
            base_q   <= '0;
        end else if (load) begin
            vec_q    <= vec_in;
            user_q   <= user_in;
            status_q <= status_in;
            pc_q     <= pc_in;
            sp_q     <= sp_in;
            ksp_q    <= ksp_in;
            base_q   <= base_in;
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer top. Accepts a request when enabled and idle,
// clears user mode, saves state, reads the handler vector and reports the
// outcome with a one-cycle pulse. Assumes the read response arrives no
// earlier than the cycle after rd_req and that the core applies strobes
// in the cycle they are high.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int W           = 32,
    parameter int VEC_W       = 8,
    parameter int ST_SHIFT    = 10,
    parameter int ST_FIELD_W  = 30,
    parameter int EXS_SHIFT   = 8,
    parameter int STRIDE_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             irq_en,
    input  logic             user_mode,
    input  logic [W-1:0]     cur_status,
    input  logic [W-1:0]     cur_pc,
    input  logic [W-1:0]     cur_sp,
    input  logic [W-1:0]     kernel_sp,
    input  logic [W-1:0]     exc_base,
    output logic             rd_req,
    output logic [W-1:0]     rd_addr,
    input  logic             rd_valid,
    input  logic             rd_err,
    input  logic [W-1:0]     rd_data,
    output logic             umode_clr,
    output logic             status_we,
    output logic [W-1:0]     status_wdata,
    output logic             usp_we,
    output logic [W-1:0]     usp_wdata,
    output logic             sp_we,
    output logic [W-1:0]     sp_wdata,
    output logic             erp_we,
    output logic [W-1:0]     erp_wdata,
    output logic             exs_we,
    output logic [W-1:0]     exs_wdata,
    output logic             eda_we,
    output logic [W-1:0]     eda_wdata,
    output logic             pc_we,
    output logic [W-1:0]     pc_wdata,
    output logic             busy,
    output logic             done_ok,
    output logic             done_rej,
    output logic [W-1:0]     result_pc
);
    seq_state_t       state_q, state_d;
    logic             accept;
    logic [VEC_W-1:0] vec_q;
    logic             user_q;
    logic [W-1:0]     status_q, pc_q, sp_q, ksp_q, base_q;
    logic [W-1:0]     status_new, table_addr, handler;
    logic [W-1:0]     final_pc_q;
    logic             ok_q;

    assign accept = (state_q == ST_IDLE) && irq_req && irq_en;

    irq_ctx_capture #(.W(W), .VEC_W(VEC_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .vec_in(irq_vec), .user_in(user_mode), .status_in(cur_status),
        .pc_in(cur_pc), .sp_in(cur_sp), .ksp_in(kernel_sp), .base_in(exc_base),
        .vec_q(vec_q), .user_q(user_q), .status_q(status_q), .pc_q(pc_q),
        .sp_q(sp_q), .ksp_q(ksp_q), .base_q(base_q)
    );

    irq_status_xform #(.W(W), .SHIFT(ST_SHIFT), .FIELD_W(ST_FIELD_W)) u_xf (
        .old_status(status_q), .new_status(status_new)
    );

    irq_vec_fetch #(.AW(W), .VEC_W(VEC_W), .STRIDE_LOG2(STRIDE_LOG2)) u_vf (
        .base(base_q), .vec(vec_q), .rd_data(rd_data),
        .addr(table_addr), .handler(handler)
    );

    // Next-state selection for the entry sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_KERN;
            ST_KERN:  state_d = ST_SAVE;
            ST_SAVE:  state_d = ST_FETCH;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (rd_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the read outcome and the resulting PC when the response lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q       <= 1'b0;
            final_pc_q <= '0;
        end else if (state_q == ST_WAIT && rd_valid) begin
            ok_q       <= !rd_err;
            final_pc_q <= rd_err ? pc_q : handler;
        end
    end

    // Strobes and data decoded from the current step.
    always_comb begin
        umode_clr    = (state_q == ST_KERN);
        status_we    = (state_q == ST_SAVE);
        status_wdata = status_new;
        usp_we       = (state_q == ST_SAVE) && user_q;
        usp_wdata    = sp_q;
        sp_we        = (state_q == ST_SAVE) && user_q;
        sp_wdata     = ksp_q;
        erp_we       = (state_q == ST_SAVE);
        erp_wdata    = pc_q;
        exs_we       = (state_q == ST_SAVE);
        exs_wdata    = W'(vec_q) << EXS_SHIFT;
        eda_we       = (state_q == ST_SAVE);
        eda_wdata    = '0;
        rd_req       = (state_q == ST_FETCH);
        rd_addr      = table_addr;
        done_ok      = (state_q == ST_DONE) && ok_q;
        done_rej     = (state_q == ST_DONE) && !ok_q;
        pc_we        = done_ok;
        pc_wdata     = final_pc_q;
        result_pc    = final_pc_q;
        busy         = (state_q != ST_IDLE);
    end

    // R3: no state write may precede the user-mode clear.
    p_clear_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we || usp_we || sp_we || erp_we || exs_we || eda_we) |-> $past(umode_clr));
    // R3: the clear cycle carries no other write.
    p_clear_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        umode_clr |-> !(status_we || usp_we || sp_we || erp_we || exs_we || eda_we || pc_we));
    // R5: stack swap writes travel together.
    p_swap_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        usp_we |-> (sp_we && status_we));
    // R7: the table read is a single-cycle request.
    p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R8: a PC write only comes with a successful completion.
    p_pc_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (done_ok && !done_rej));
    // R9: completion follows a sampled response.
    p_done_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok || done_rej) |-> $past(rd_valid));
    // R2: a disabled request leaves the block idle.
    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && !irq_en) |=> !busy);
    // R10: busy only rises after an enabled request.
    p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(irq_req && irq_en));
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic        irq_en = 1'b0;
    logic        user_mode = 1'b0;
    logic [31:0] cur_status = '0, cur_pc = '0, cur_sp = '0, kernel_sp = '0, exc_base = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid = 1'b0, rd_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic        umode_clr, status_we, usp_we, sp_we, erp_we, exs_we, eda_we, pc_we;
    logic [31:0] status_wdata, usp_wdata, sp_wdata, erp_wdata, exs_wdata, eda_wdata, pc_wdata;
    logic        busy, done_ok, done_rej;
    logic [31:0] result_pc;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .irq_en(irq_en),
        .user_mode(user_mode), .cur_status(cur_status), .cur_pc(cur_pc), .cur_sp(cur_sp),
        .kernel_sp(kernel_sp), .exc_base(exc_base), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data), .umode_clr(umode_clr),
        .status_we(status_we), .status_wdata(status_wdata), .usp_we(usp_we),
        .usp_wdata(usp_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .erp_we(erp_we),
        .erp_wdata(erp_wdata), .exs_we(exs_we), .exs_wdata(exs_wdata), .eda_we(eda_we),
        .eda_wdata(eda_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata), .busy(busy),
        .done_ok(done_ok), .done_rej(done_rej), .result_pc(result_pc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] strobes();
        return {umode_clr, status_we, usp_we, sp_we, erp_we, exs_we, eda_we, pc_we};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "strobes", {24'd0, strobes()}, 32'd0);
        chk("R1", "rd_req/done", {29'd0, rd_req, done_ok, done_rej}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_disabled();
        irq_en = 1'b0; irq_req = 1'b1; irq_vec = 8'h21;
        repeat (3) begin
            @(negedge clk);
            chk("R2", "busy while disabled", {31'd0, busy}, 32'd0);
            chk("R2", "strobes while disabled", {23'd0, rd_req, strobes()}, 32'd0);
        end
        irq_req = 1'b0;
        @(negedge clk);
    endtask

    // One full entry; err selects a failing table read, lat >= 1.
    task automatic t_entry(input logic [7:0] vec, input logic umode, input logic [31:0] st,
                           input logic [31:0] pc, input logic [31:0] sp, input logic [31:0] ksp,
                           input logic [31:0] base, input logic [31:0] data, input logic err,
                           input int lat);
        logic [31:0] exp_st;
        exp_st = ((st << 10) & 32'h3FFF_FFFF) | (st & 32'h8000_0000);
        irq_vec = vec; user_mode = umode; cur_status = st; cur_pc = pc; cur_sp = sp;
        kernel_sp = ksp; exc_base = base; irq_en = 1'b1; irq_req = 1'b1;
        @(negedge clk);
        // KERN step; scramble context to show the snapshot is used (R6).
        irq_req = 1'b0;
        irq_vec = ~vec; user_mode = ~umode; cur_status = ~st; cur_pc = ~pc;
        cur_sp = ~sp; kernel_sp = ~ksp; exc_base = ~base;
        chk("R3", "umode_clr only", {24'd0, strobes()}, 32'h80);
        chk("R10", "busy after accept", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R3", "clear is one cycle", {31'd0, umode_clr}, 32'd0);
        chk("R4", "status_we", {31'd0, status_we}, 32'd1);
        chk("R4", "status_wdata", status_wdata, exp_st);
        chk("R5", "usp_we", {31'd0, usp_we}, {31'd0, umode});
        chk("R5", "sp_we", {31'd0, sp_we}, {31'd0, umode});
        if (umode) begin
            chk("R5", "usp_wdata", usp_wdata, sp);
            chk("R5", "sp_wdata", sp_wdata, ksp);
        end
        chk("R6", "erp", {erp_we, erp_wdata[30:0]}, {1'b1, pc[30:0]});
        chk("R6", "erp_wdata", erp_wdata, pc);
        chk("R6", "exs_wdata", exs_wdata, {16'd0, vec, 8'd0});
        chk("R6", "eda", {eda_we, exs_we, eda_wdata[29:0]}, 32'hC000_0000);
        @(negedge clk);
        chk("R7", "rd_req", {31'd0, rd_req}, 32'd1);
        chk("R7", "rd_addr", rd_addr, base + {22'd0, vec, 2'b00});
        chk("R7", "no writes during fetch", {24'd0, strobes()}, 32'd0);
        irq_req = 1'b1; irq_en = 1'b1;   // request while busy (R10)
        repeat (lat) begin
            @(negedge clk);
            chk("R7", "rd_req single", {31'd0, rd_req}, 32'd0);
            chk("R10", "busy while waiting", {31'd0, busy}, 32'd1);
        end
        irq_req = 1'b0;
        rd_valid = 1'b1; rd_err = err; rd_data = data;
        @(negedge clk);
        rd_valid = 1'b0; rd_err = 1'b0; rd_data = 32'hDEAD_BEEF;
        if (!err) begin
            chk("R8", "done_ok/done_rej/pc_we", {29'd0, done_ok, done_rej, pc_we}, 32'd5);
            chk("R8", "pc_wdata", pc_wdata, data);
            chk("R8", "result_pc", result_pc, data);
        end else begin
            chk("R9", "done_ok/done_rej/pc_we", {29'd0, done_ok, done_rej, pc_we}, 32'd2);
            chk("R9", "result_pc", result_pc, pc);
        end
        chk("R10", "busy in completion", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R10", "idle after completion", {31'd0, busy}, 32'd0);
        chk("R10", "no pulse after completion", {30'd0, done_ok, done_rej}, 32'd0);
        @(negedge clk);
        chk("R10", "busy-time request dropped", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_entry(8'h03, 1'b1, 32'hC123_4567, 32'h0000_1000, 32'h0000_8000, 32'h0001_0000,
                32'h4000_0000, 32'h0403_0201, 1'b0, 1);
        t_entry(8'hFF, 1'b0, 32'h7FFF_FFFF, 32'h8000_0002, 32'h1234_0000, 32'hAAAA_5554,
                32'hFFFF_FC00, 32'h8877_6655, 1'b0, 4);
        t_entry(8'h00, 1'b1, 32'h8000_0001, 32'h0BAD_F00C, 32'h0000_0010, 32'h0000_0020,
                32'h0000_0100, 32'h1111_2222, 1'b1, 2);
        t_entry(8'h40, 1'b0, 32'h0030_0000, 32'h0000_0044, 32'h0000_1110, 32'h0000_2220,
                32'h0002_0000, 32'hCAFE_0001, 1'b0, 1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule